// File: doc/BRIEF.md
# Two-Byte Sound Command Sender

This block sits on the host side of a parallel command bus that feeds a DSP-based audio subsystem. A press of a pushbutton launches one sound command. The command is always a two-byte packet: a fixed high byte is written first, and the low byte carries a value taken from four switches, so the reachable commands run from 0x0001 to 0x000F. Each byte is written into a command latch. The write raises an interrupt flag toward the DSP, and the DSP clears that flag by reading the latch.

The receiver drops a packet when the second byte arrives more than 1 ms after the first. For that reason the sender writes the low byte a short, fixed gap after the DSP has taken the high byte. The default gap is 100 us at 50 MHz. The pushbutton input is synchronized and debounced. A busy output covers the span of the whole packet. If the DSP leaves a byte unread for too long, the sender abandons the packet, withdraws the flag and sets a sticky timeout bit.

Top module: `sc_cmd_sender`

## Requirements
- R1: After reset, bus_wr, irq, busy and timeout_flag are 0, and latch_data is 0.
- R2: A debounced press taken while idle, with a nonzero switch value, does the following:
  - It issues a one-cycle bus_wr with bus_data = HI_BYTE (default 0x00). bus_addr equals CMD_ADDR (default 0x10) during every write.
  - It later issues a second one-cycle write with bus_data = {4'b0000, switches}.
  - The switch value used for the second write is the one sampled when the press was accepted.
- R3: A press while the switches read 0 starts no write.
- R4: A button level that lasts fewer than DEBOUNCE_CYC cycles starts nothing. A press held for a long time yields exactly one packet.
- R5: A write to CMD_ADDR loads latch_data and sets irq on the next clock edge. dsp_rd sampled while irq is 1 clears irq on that edge.
- R6: No byte is written while irq is 1. The low byte's bus_wr goes high exactly GAP_CYC cycles after the edge that sampled the DSP's read of the high byte.
- R7: busy rises together with the first bus_wr. It stays 1 until the edge that samples the DSP's read of the low byte, and it is 0 after that edge.
- R8: Presses that arrive while busy is 1 are ignored. They write nothing, they do not change the latch, and they do not start a packet afterwards.
- R9: If a written byte is still unread TIMEOUT_CYC cycles after the edge that wrote it, all of the following happen on that edge:
  - timeout_flag is set.
  - busy and irq drop.
  - The sender returns to idle.
- R10: timeout_flag, once set, stays 1 until reset, including across later packets that complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_raw | input | 1 | Unsynchronized start pushbutton, active high |
| sw | input | SW_W (4) | Switches giving the low nibble of the command |
| dsp_rd | input | 1 | DSP read strobe of the command latch |
| bus_addr | output | ADDR_W (5) | Command bus address, CMD_ADDR during a write |
| bus_data | output | DATA_W (8) | Command bus data |
| bus_wr | output | 1 | Command bus write strobe, one cycle per byte |
| latch_data | output | DATA_W (8) | Command latch contents seen by the DSP |
| irq | output | 1 | Interrupt flag to the DSP, cleared by its read |
| busy | output | 1 | A packet is in progress |
| timeout_flag | output | 1 | Sticky: a byte was left unread too long |

## Verification
A table of switch values is sent as complete packets: 0x1, 0x5, 0xA and 0xF. These show the low byte tracking each switch bit, and they also measure the exact cycle gap and the busy span of each packet.

Several directed cases test acceptance of a press:
- A zero switch value.
- A button glitch shorter than the debounce window.
- A second press, with the switches changed, while a packet is still in progress. This case separates switches captured at the press from switches read live.

Unread high and low bytes are left to expire, which checks the exact timeout cycle and the withdrawal of the flag. A complete packet after a timeout shows that the timeout bit holds.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    S_IDLE    = 2'd0,
    S_WAIT_HI = 2'd1,
    S_GAP     = 2'd2,
    S_WAIT_LO = 2'd3
  } sc_state_e;
endpackage

// File: rtl/sc_debounce.sv
module sc_debounce #(
  parameter int unsigned DEBOUNCE_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic press
);
  localparam int unsigned CW = $clog2(DEBOUNCE_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEBOUNCE_CYC - 1);

  logic meta_q, sync_q, stable_q, stable_d, press_q, press_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d    = cnt_q;
    stable_d = stable_q;
    press_d  = 1'b0;
    if (sync_q == stable_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_d    = '0;
      stable_d = sync_q;
      press_d  = sync_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= 1'b0;
      sync_q   <= 1'b0;
      stable_q <= 1'b0;
      press_q  <= 1'b0;
      cnt_q    <= '0;
    end else begin
      meta_q   <= raw;
      sync_q   <= meta_q;
      stable_q <= stable_d;
      press_q  <= press_d;
      cnt_q    <= cnt_d;
    end
  end

  assign press = press_q;
endmodule

// File: rtl/sc_latch.sv
module sc_latch #(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CMD_ADDR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              rd,
  input  logic              abort,
  output logic [DATA_W-1:0] q,
  output logic              irq
);
  logic [DATA_W-1:0] q_q, q_d;
  logic              irq_q, irq_d;
  logic              hit;

  assign hit = wr && (addr == ADDR_W'(CMD_ADDR));

  always_comb begin
    q_d   = q_q;
    irq_d = irq_q;
    if (hit) begin
      q_d   = data;
      irq_d = 1'b1;
    end else if (rd || abort) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= '0;
      irq_q <= 1'b0;
    end else begin
      if (hit) q_q <= q_d;
      irq_q <= irq_d;
    end
  end

  assign q   = q_q;
  assign irq = irq_q;
endmodule

// File: rtl/sc_sequencer.sv
module sc_sequencer
  import sc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SW_W        = 4,
  parameter int unsigned CMD_ADDR    = 16,
  parameter int unsigned HI_BYTE     = 0,
  parameter int unsigned GAP_CYC     = 5000,
  parameter int unsigned TIMEOUT_CYC = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              press,
  input  logic [SW_W-1:0]   sw,
  input  logic              irq,
  input  logic              dsp_rd,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              busy,
  output logic              timeout_flag,
  output logic              abort
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
  localparam int unsigned GW = $clog2(GAP_CYC + 1);
  localparam logic [TW-1:0] TMR_LAST = TW'(TIMEOUT_CYC - 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

  sc_state_e         state_q, state_d;
  logic [SW_W-1:0]   sw_q, sw_d;
  logic [TW-1:0]     tmr_q, tmr_d;
  logic [GW-1:0]     gap_q, gap_d;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              busy_q, busy_d;
  logic              to_q, to_d;
  logic              consumed;
  logic              expired;

  assign consumed = dsp_rd && irq;
  assign expired  = (tmr_q == TMR_LAST) && !consumed;

  always_comb begin
    state_d = state_q;
    sw_d    = sw_q;
    tmr_d   = tmr_q;
    gap_d   = gap_q;
    wr_d    = 1'b0;
    data_d  = data_q;
    busy_d  = busy_q;
    to_d    = to_q;
    abort   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (press && (sw != '0)) begin
          sw_d    = sw;
          wr_d    = 1'b1;
          data_d  = DATA_W'(HI_BYTE);
          busy_d  = 1'b1;
          tmr_d   = '0;
          state_d = S_WAIT_HI;
        end
      end
      S_WAIT_HI: begin
        if (consumed) begin
          gap_d   = '0;
          state_d = S_GAP;
        end else if (expired) begin
          abort   = 1'b1;
          to_d    = 1'b1;
          busy_d  = 1'b0;
          state_d = S_IDLE;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      S_GAP: begin
        if (gap_q == GAP_LAST) begin
          wr_d    = 1'b1;
          data_d  = DATA_W'(sw_q);
          tmr_d   = '0;
          state_d = S_WAIT_LO;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      S_WAIT_LO: begin
        if (consumed) begin
          busy_d  = 1'b0;
          state_d = S_IDLE;
        end else if (expired) begin
          abort   = 1'b1;
          to_d    = 1'b1;
          busy_d  = 1'b0;
          state_d = S_IDLE;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
    addr_d = wr_d ? ADDR_W'(CMD_ADDR) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sw_q    <= '0;
      tmr_q   <= '0;
      gap_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      busy_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE) sw_q <= sw_d;
      tmr_q   <= tmr_d;
      gap_q   <= gap_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      if (wr_d) data_q <= data_d;
      busy_q  <= busy_d;
      to_q    <= to_d;
    end
  end

  assign bus_wr       = wr_q;
  assign bus_addr     = addr_q;
  assign bus_data     = data_q;
  assign busy         = busy_q;
  assign timeout_flag = to_q;
endmodule

// File: rtl/sc_cmd_sender.sv
module sc_cmd_sender #(
  parameter int unsigned ADDR_W       = 5,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned SW_W         = 4,
  parameter int unsigned CMD_ADDR     = 16,
  parameter int unsigned HI_BYTE      = 0,
  parameter int unsigned DEBOUNCE_CYC = 500000,
  parameter int unsigned GAP_CYC      = 5000,
  parameter int unsigned TIMEOUT_CYC  = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_raw,
  input  logic [SW_W-1:0]   sw,
  input  logic              dsp_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_wr,
  output logic [DATA_W-1:0] latch_data,
  output logic              irq,
  output logic              busy,
  output logic              timeout_flag
);
  logic press;
  logic abort;

  sc_debounce #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_deb (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (btn_raw),
    .press (press)
  );

  sc_sequencer #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SW_W        (SW_W),
    .CMD_ADDR    (CMD_ADDR),
    .HI_BYTE     (HI_BYTE),
    .GAP_CYC     (GAP_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .press        (press),
    .sw           (sw),
    .irq          (irq),
    .dsp_rd       (dsp_rd),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_data     (bus_data),
    .busy         (busy),
    .timeout_flag (timeout_flag),
    .abort        (abort)
  );

  sc_latch #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CMD_ADDR (CMD_ADDR)
  ) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .data  (bus_data),
    .rd    (dsp_rd),
    .abort (abort),
    .q     (latch_data),
    .irq   (irq)
  );
endmodule

// File: rtl/sc_cmd_sender_chk.sv
module sc_cmd_sender_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_wr,
  input logic irq,
  input logic dsp_rd,
  input logic busy,
  input logic timeout_flag
);
  // R2: each byte write is a single-cycle strobe
  a_r2_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr);

  // R5: the flag only rises after a write
  a_r5_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(bus_wr));

  // R5 / R9: the flag only falls on a read or an abandoned packet
  a_r5_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(dsp_rd) || $fell(busy)));

  // R6: no byte overwrites an unread one
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> !irq);

  // R7: every write happens inside a busy span
  a_r7_busy_on_wr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> busy);

  // R7: busy only starts with a write
  a_r7_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bus_wr);

  // R10: the timeout bit is sticky
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag);
endmodule

bind sc_cmd_sender sc_cmd_sender_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .irq          (irq),
  .dsp_rd       (dsp_rd),
  .busy         (busy),
  .timeout_flag (timeout_flag)
);

// File: tb/sc_cmd_sender_test.sv
module sc_cmd_sender_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEB  = 8;
  localparam int GAP  = 6;
  localparam int TO   = 200;
  localparam int ADDR = 16;
  localparam logic [7:0] HI = 8'h00;
  // {switches, expected low byte}
  localparam logic [11:0] VEC [4] = '{
    {4'h1, 8'h01}, {4'h5, 8'h05}, {4'hA, 8'h0A}, {4'hF, 8'h0F}};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       btn_raw;
  logic [3:0] sw;
  logic       dsp_rd;
  logic [4:0] bus_addr;
  logic [7:0] bus_data;
  logic       bus_wr;
  logic [7:0] latch_data;
  logic       irq;
  logic       busy;
  logic       timeout_flag;

  int checks = 0;
  int errors = 0;
  int wr_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_cmd_sender #(
    .CMD_ADDR(ADDR), .HI_BYTE(0), .DEBOUNCE_CYC(DEB),
    .GAP_CYC(GAP), .TIMEOUT_CYC(TO)
  ) uut (
    .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .sw(sw), .dsp_rd(dsp_rd),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_wr(bus_wr),
    .latch_data(latch_data), .irq(irq), .busy(busy),
    .timeout_flag(timeout_flag)
  );

  always @(posedge clk) if (bus_wr) wr_count <= wr_count + 1;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic catch_wr(output bit got);
    got = 1'b0;
    for (int i = 0; i < 6*DEB; i++) begin
      @(negedge clk);
      if (bus_wr) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic dsp_read();
    dsp_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dsp_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_packet(input logic [3:0] s, input logic [7:0] lo);
    bit got;
    int w0;
    sw = s;
    w0 = wr_count;
    btn_raw = 1'b1;
    catch_wr(got);
    check(got, "R2 first write", got, 1);
    check(bus_data == HI && bus_addr == 5'(ADDR), "R2 high byte/addr",
          {bus_addr, bus_data}, {5'(ADDR), HI});
    check(busy, "R7 busy with first write", busy, 1);
    @(negedge clk);
    check(irq && latch_data == HI, "R5 latch load", {irq, latch_data}, {1'b1, HI});
    dsp_read();
    check(!irq && busy, "R5 read clears irq, R7 busy held", {irq, busy}, 2'b01);
    repeat (GAP-1) @(posedge clk);
    @(negedge clk);
    check(!bus_wr, "R6 gap not early", bus_wr, 0);
    @(posedge clk);
    @(negedge clk);
    check(bus_wr && bus_data == lo, "R6 gap exact, R2 low byte",
          {bus_wr, bus_data}, {1'b1, lo});
    @(negedge clk);
    check(irq && latch_data == lo, "R5 latch low byte", {irq, latch_data}, {1'b1, lo});
    dsp_read();
    check(!busy && !irq, "R7 busy ends on second read", {busy, irq}, 0);
    check(wr_count == w0 + 2, "R2 two writes", wr_count - w0, 2);
    idle(3*DEB);
    check(wr_count == w0 + 2, "R4 held press gives one packet", wr_count - w0, 2);
    btn_raw = 1'b0;
    idle(3*DEB);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit got;
    int w0;
    rst_n = 1'b0; btn_raw = 1'b0; sw = 4'h0; dsp_rd = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!bus_wr && !irq && !busy && !timeout_flag && latch_data == 8'h00,
          "R1 reset state", {bus_wr, irq, busy, timeout_flag, latch_data}, 0);
    rst_n = 1'b1;
    idle(2);

    foreach (VEC[i]) run_packet(VEC[i][11:8], VEC[i][7:0]);
    check(!timeout_flag, "R9 no timeout on served packets", timeout_flag, 0);

    // R3: zero switches
    sw = 4'h0; w0 = wr_count; btn_raw = 1'b1;
    catch_wr(got);
    check(!got && !busy, "R3 zero switches ignored", {got, busy}, 0);
    btn_raw = 1'b0; idle(3*DEB);

    // R4: short glitch
    sw = 4'h2; w0 = wr_count;
    btn_raw = 1'b1; idle(DEB/2); btn_raw = 1'b0;
    idle(4*DEB);
    check(wr_count == w0 && !busy, "R4 glitch ignored", wr_count - w0, 0);

    // R8: press during busy
    sw = 4'h7; w0 = wr_count; btn_raw = 1'b1;
    catch_wr(got);
    @(negedge clk);
    btn_raw = 1'b0; idle(3*DEB);
    sw = 4'h9; btn_raw = 1'b1; idle(3*DEB);
    check(wr_count == w0 + 1 && latch_data == HI && busy, "R8 press while busy ignored",
          wr_count - w0, 1);
    dsp_read();
    catch_wr(got);
    check(got && bus_data == 8'h07, "R2 switches captured at press", bus_data, 8'h07);
    @(negedge clk);
    dsp_read();
    idle(3*DEB);
    check(wr_count == w0 + 2 && !busy, "R8 no late packet", wr_count - w0, 2);
    btn_raw = 1'b0; idle(3*DEB);

    // R9: high byte left unread
    sw = 4'h3; btn_raw = 1'b1;
    catch_wr(got);
    repeat (TO-1) @(posedge clk);
    @(negedge clk);
    check(!timeout_flag && busy && irq, "R9 not early (high)",
          {timeout_flag, busy, irq}, 3'b011);
    @(posedge clk);
    @(negedge clk);
    check(timeout_flag && !busy && !irq, "R9 timeout on high byte",
          {timeout_flag, busy, irq}, 3'b100);
    btn_raw = 1'b0; idle(3*DEB);

    // R10: sticky across a served packet
    run_packet(4'hC, 8'h0C);
    check(timeout_flag, "R10 timeout sticky", timeout_flag, 1);

    // R9: low byte left unread
    sw = 4'h6; btn_raw = 1'b1;
    catch_wr(got);
    @(negedge clk);
    dsp_read();
    catch_wr(got);
    check(got && bus_data == 8'h06, "R2 low byte before timeout", bus_data, 8'h06);
    repeat (TO-1) @(posedge clk);
    @(negedge clk);
    check(busy && irq, "R9 not early (low)", {busy, irq}, 2'b11);
    @(posedge clk);
    @(negedge clk);
    check(timeout_flag && !busy && !irq, "R9 timeout on low byte",
          {timeout_flag, busy, irq}, 3'b100);
    btn_raw = 1'b0; idle(3*DEB);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule